// File: doc/BRIEF.md
# Stack Divide Instruction Sequencer

This block takes the register and memory encodings of the floating-point divide instruction family and runs them against an eight-entry register stack. Operands are named relative to a rotating top-of-stack pointer. The opcode byte chooses which of the two stack operands is the dividend. It also decides whether the stack is popped after the result is written back. Memory divisors can arrive as 32-bit or 64-bit IEEE floats, or as 32-bit or 16-bit two's-complement integers. They are widened to an 80-bit internal extended format before they are used.

Once decoded, the block registers the dividend and divisor and offers them to an external divide unit through a valid/ready request. It then accepts the quotient through a valid/ready response and writes it to the destination entry. When the encoding asks for it, the block pops the stack in the same cycle. The block is busy from the moment it accepts an instruction until the response is taken. If an operand register is empty, the instruction ends at once with a stack fault. The stack is loaded through a push port. The internal format is laid out as bit 79 sign, bits 78:64 exponent with bias 16383, and bits 63:0 mantissa with an explicit integer bit.

Top module: `fdv_seq`

## Requirements
- R1: After synchronous reset, TOP is 0, all eight tags read empty (tag bit 1 means valid), and busy, done, stk_fault, c1 and dv_req_valid are all 0.
- R2: Opcode D8 with ModRM 11_110_iii divides ST(0) by ST(i) and writes ST(0), with no pop.
- R3: Opcode DC with ModRM 11_111_iii divides ST(i) by ST(0) and writes ST(i), with no pop.
- R4: Opcode DE with ModRM 11_111_iii divides ST(i) by ST(0), writes ST(i), then clears the tag of the old ST(0) and adds 1 to TOP modulo 8. When i=0, the pop empties the entry that was just written.
- R5: When ModRM mod is not 11 and ModRM bits 5:3 are 110, the divisor comes from mem_data and ST(0) is both the dividend and the destination, with no pop. The opcode gives the format: D8 is float32 in bits 31:0, DC is float64, DA is int32 in bits 31:0, and DE is int16 in bits 15:0.
- R6: An integer divisor becomes a normalized extended value with the integer's sign and magnitude. Integer zero becomes +0, which is all 80 bits zero.
- R7: A float divisor is re-biased into the extended format. A signed zero keeps its sign. A denormal is normalized. An all-ones exponent becomes exponent 7FFF with the integer bit set and the fraction kept.
- R8: If ST(0) is empty, or a register-form ST(i) is empty, no divide request is made. done pulses in the cycle after acceptance with stk_fault=1 and c1=0, and TOP and the tags are unchanged.
- R9: dv_req_valid rises the cycle after acceptance and holds with stable dv_a/dv_b until dv_req_ready. dv_rsp_ready is high only after the request handshake. Write-back and pop take effect at the response handshake, and done pulses in the next cycle. busy is high from acceptance until then.
- R10: On a response with dv_suppress=1, nothing is written and nothing is popped, and c1 reads 0. Otherwise c1 takes dv_round_up and stk_fault reads 0.
- R11: An unrecognised opcode/ModRM pair is ignored. A push is taken only when the block is idle and ins_valid is low. A push decrements TOP modulo 8, writes the new ST(0) and marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present |
| ins_opc | input | 8 | Opcode byte |
| ins_modrm | input | 8 | ModRM byte |
| mem_data | input | 64 | Memory divisor, low-aligned |
| psh_valid | input | 1 | Push request |
| psh_data | input | 80 | Extended value to push |
| busy | output | 1 | Divide in progress; instructions held off |
| done | output | 1 | One-cycle pulse at instruction completion |
| stk_fault | output | 1 | Last completion was a stack underflow |
| c1 | output | 1 | Condition bit C1 of last completion |
| top_o | output | 3 | Top-of-stack pointer |
| tag_o | output | 8 | Per-physical-entry valid bits |
| dv_req_valid | output | 1 | Divide request valid |
| dv_req_ready | input | 1 | Divider accepts request |
| dv_a | output | 80 | Dividend |
| dv_b | output | 80 | Divisor |
| dv_rsp_valid | input | 1 | Quotient valid |
| dv_rsp_ready | output | 1 | Sequencer waiting for quotient |
| dv_q | input | 80 | Quotient |
| dv_round_up | input | 1 | Quotient was rounded up |
| dv_suppress | input | 1 | Unmasked exception: store nothing |

## Verification
A request appears one cycle after the acceptance edge. An underflow completion, and the done pulse that follows a response handshake, appear one cycle after their causing edge, and TOP, the tags and c1 are updated on that same edge. The bench drives inputs at falling edges. It records each handshake at the rising edge and compares at the next falling edge, so every check lands in the first cycle its result can be seen. The divider stub is run with both zero and multi-cycle request and response latencies, to show that operands hold and that write-back waits for the response. Each written value is then observed as an operand of a later divide.

// File: rtl/fdv_pkg.sv
package fdv_pkg;
  localparam int EXT_W    = 80;
  localparam int EXP_W    = 15;
  localparam int MAN_W    = 64;
  localparam int EXT_BIAS = 16383;
  localparam int SEL_W    = 3;
  localparam int MEM_W    = 64;

  typedef enum logic [1:0] {MF_F32, MF_F64, MF_I32, MF_I16} memfmt_t;

  typedef struct packed {
    logic             ok;
    logic             mem;
    memfmt_t          fmt;
    logic [SEL_W-1:0] sel;
    logic             rev;   // dividend is ST(i), destination ST(i)
    logic             pop;
  } dctl_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_t;

  function automatic logic [6:0] lzc64(input logic [MAN_W-1:0] x);
    logic [6:0] n;
    n = 7'd64;
    for (int k = 0; k < MAN_W; k++)
      if (x[k]) n = 7'(MAN_W - 1 - k);
    return n;
  endfunction

  function automatic logic [EXT_W-1:0] int_to_ext(input logic [MAN_W-1:0] v);
    logic [MAN_W-1:0] mag;
    logic [6:0]       lz;
    mag = v[MAN_W-1] ? (~v + 64'd1) : v;
    lz  = lzc64(mag);
    if (mag == '0) return '0;
    return {v[MAN_W-1], EXP_W'(EXT_BIAS + MAN_W - 1 - int'(lz)), mag << lz};
  endfunction

  function automatic logic [EXT_W-1:0] flt_to_ext(input logic s, input logic [10:0] e,
                                                  input logic [62:0] f, input int bias,
                                                  input logic [10:0] eall);
    logic [MAN_W-1:0] m;
    logic [6:0]       lz;
    int               ex;
    m  = {1'b0, f};
    lz = lzc64(m);
    ex = 0;
    if (e == eall) return {s, {EXP_W{1'b1}}, 1'b1, f};
    if (e == '0 && f == '0) return {s, {(EXT_W-1){1'b0}}};
    if (e == '0) begin
      ex = EXT_BIAS - bias + 1 - int'(lz);
      return {s, EXP_W'(ex), m << lz};
    end
    ex = int'(e) - bias + EXT_BIAS;
    return {s, EXP_W'(ex), 1'b1, f};
  endfunction
endpackage

// File: rtl/fdv_decode.sv
module fdv_decode
  import fdv_pkg::*;
(
  input  logic [7:0] opc,
  input  logic [7:0] modrm,
  output dctl_t      ctl
);
  logic       is_reg;
  logic [2:0] rf;

  assign is_reg = (modrm[7:6] == 2'b11);
  assign rf     = modrm[5:3];

  always_comb begin
    ctl = '0;
    if (is_reg) begin
      ctl.sel = modrm[2:0];
      case (opc)
        8'hD8: ctl.ok = (rf == 3'd6);
        8'hDC: begin ctl.ok = (rf == 3'd7); ctl.rev = 1'b1; end
        8'hDE: begin ctl.ok = (rf == 3'd7); ctl.rev = 1'b1; ctl.pop = 1'b1; end
        default: ctl.ok = 1'b0;
      endcase
    end else if (rf == 3'd6) begin
      ctl.mem = 1'b1;
      case (opc)
        8'hD8: begin ctl.ok = 1'b1; ctl.fmt = MF_F32; end
        8'hDC: begin ctl.ok = 1'b1; ctl.fmt = MF_F64; end
        8'hDA: begin ctl.ok = 1'b1; ctl.fmt = MF_I32; end
        8'hDE: begin ctl.ok = 1'b1; ctl.fmt = MF_I16; end
        default: ctl.ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fdv_memcvt.sv
module fdv_memcvt
  import fdv_pkg::*;
(
  input  memfmt_t          fmt,
  input  logic [MEM_W-1:0] raw,
  output logic [EXT_W-1:0] ext
);
  always_comb begin
    case (fmt)
      MF_F32:  ext = flt_to_ext(raw[31], {3'b000, raw[30:23]}, {raw[22:0], 40'b0}, 127, 11'd255);
      MF_F64:  ext = flt_to_ext(raw[63], raw[62:52], {raw[51:0], 11'b0}, 1023, 11'd2047);
      MF_I32:  ext = int_to_ext({{32{raw[31]}}, raw[31:0]});
      default: ext = int_to_ext({{48{raw[15]}}, raw[15:0]});
    endcase
  end
endmodule

// File: rtl/fdv_stack.sv
module fdv_stack #(
  parameter  int DEPTH = 8,
  parameter  int DW    = 80,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    rel_a,
  input  logic [PW-1:0]    rel_b,
  output logic [DW-1:0]    rd_a,
  output logic [DW-1:0]    rd_b,
  output logic             vld_a,
  output logic             vld_b,
  input  logic             push_en,
  input  logic [DW-1:0]    push_data,
  input  logic             wb_en,
  input  logic [PW-1:0]    wb_rel,
  input  logic [DW-1:0]    wb_data,
  input  logic             pop_en,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] tag_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    top_q;
  logic [DEPTH-1:0] tag_q;
  logic [PW-1:0]    pa, pb, waddr;
  logic             we;
  logic [DW-1:0]    wdata;

  assign pa    = top_q + rel_a;
  assign pb    = top_q + rel_b;
  assign rd_a  = mem[pa];
  assign rd_b  = mem[pb];
  assign vld_a = tag_q[pa];
  assign vld_b = tag_q[pb];
  assign we    = push_en | wb_en;
  assign waddr = push_en ? top_q - PW'(1) : top_q + wb_rel;
  assign wdata = push_en ? push_data : wb_data;
  assign top_o = top_q;
  assign tag_o = tag_q;

  // single write port, no reset on storage
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          top_q <= '0;
    else if (push_en) top_q <= top_q - PW'(1);
    else if (pop_en)  top_q <= top_q + PW'(1);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst)                                tag_q[e] <= 1'b0;
      else if (pop_en && top_q == PW'(e))     tag_q[e] <= 1'b0;
      else if (we && waddr == PW'(e))         tag_q[e] <= 1'b1;
    end
  end

  a_r11_push_marks_top: assert property (@(posedge clk) disable iff (rst)
    push_en |=> tag_q[top_q]);
  a_r4_pop_frees: assert property (@(posedge clk) disable iff (rst)
    pop_en |=> (!tag_q[$past(top_q)] && top_q == $past(top_q) + PW'(1)));
  a_r11_push_alone: assert property (@(posedge clk) disable iff (rst)
    push_en |-> !(wb_en || pop_en));
endmodule

// File: rtl/fdv_seq.sv
module fdv_seq
  import fdv_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [7:0]       ins_opc,
  input  logic [7:0]       ins_modrm,
  input  logic [MEM_W-1:0] mem_data,
  input  logic             psh_valid,
  input  logic [EXT_W-1:0] psh_data,
  output logic             busy,
  output logic             done,
  output logic             stk_fault,
  output logic             c1,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] tag_o,
  output logic             dv_req_valid,
  input  logic             dv_req_ready,
  output logic [EXT_W-1:0] dv_a,
  output logic [EXT_W-1:0] dv_b,
  input  logic             dv_rsp_valid,
  output logic             dv_rsp_ready,
  input  logic [EXT_W-1:0] dv_q,
  input  logic             dv_round_up,
  input  logic             dv_suppress
);
  sq_t              st;
  dctl_t            ctl;
  logic [EXT_W-1:0] cvt, rd_a, rd_b, op_a, op_b;
  logic             vld_a, vld_b, under, acc, psh, rsp_fire;
  logic [PW-1:0]    dst_q;
  logic             pop_q;

  fdv_decode u_dec (.opc(ins_opc), .modrm(ins_modrm), .ctl(ctl));
  fdv_memcvt u_cvt (.fmt(ctl.fmt), .raw(mem_data), .ext(cvt));

  fdv_stack #(.DEPTH(DEPTH), .DW(EXT_W)) u_stk (
    .clk(clk), .rst(rst),
    .rel_a('0), .rel_b(PW'(ctl.sel)),
    .rd_a(rd_a), .rd_b(rd_b), .vld_a(vld_a), .vld_b(vld_b),
    .push_en(psh), .push_data(psh_data),
    .wb_en(rsp_fire && !dv_suppress), .wb_rel(dst_q), .wb_data(dv_q),
    .pop_en(rsp_fire && pop_q && !dv_suppress),
    .top_o(top_o), .tag_o(tag_o)
  );

  assign busy         = (st != SQ_IDLE);
  assign dv_req_valid = (st == SQ_ISSUE);
  assign dv_rsp_ready = (st == SQ_WAIT);
  assign acc          = ins_valid && (st == SQ_IDLE) && ctl.ok;
  assign psh          = psh_valid && !ins_valid && (st == SQ_IDLE);
  assign rsp_fire     = dv_rsp_valid && (st == SQ_WAIT);
  assign under        = !vld_a || (!ctl.mem && !vld_b);
  assign op_a         = ctl.rev ? rd_b : rd_a;
  assign op_b         = ctl.mem ? cvt : (ctl.rev ? rd_a : rd_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      done      <= 1'b0;
      stk_fault <= 1'b0;
      c1        <= 1'b0;
      dv_a      <= '0;
      dv_b      <= '0;
      dst_q     <= '0;
      pop_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (acc) begin
          if (under) begin
            done      <= 1'b1;
            stk_fault <= 1'b1;
            c1        <= 1'b0;
          end else begin
            dv_a  <= op_a;
            dv_b  <= op_b;
            dst_q <= ctl.rev ? PW'(ctl.sel) : '0;
            pop_q <= ctl.pop;
            st    <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: if (dv_req_ready) st <= SQ_WAIT;
        SQ_WAIT: if (dv_rsp_valid) begin
          done      <= 1'b1;
          stk_fault <= 1'b0;
          c1        <= !dv_suppress && dv_round_up;
          st        <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    dv_req_valid && !dv_req_ready |=> dv_req_valid && $stable(dv_a) && $stable(dv_b));
  a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(dv_rsp_ready) |-> $past(dv_req_valid && dv_req_ready));
  a_r8_fault_clears_c1: assert property (@(posedge clk) disable iff (rst)
    done && stk_fault |-> !c1);
  a_r8_no_issue: assert property (@(posedge clk) disable iff (rst)
    acc && under |=> !dv_req_valid && top_o == $past(top_o) && tag_o == $past(tag_o));
  a_r10_suppress_keeps: assert property (@(posedge clk) disable iff (rst)
    rsp_fire && dv_suppress |=> top_o == $past(top_o) && tag_o == $past(tag_o) && !c1);
  a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
    rsp_fire && pop_q && !dv_suppress |=> top_o == $past(top_o) + PW'(1));
endmodule

// File: tb/fdv_seq_test.sv
module fdv_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, ins_valid, psh_valid, busy, done, stk_fault, c1;
  logic [7:0]  ins_opc, ins_modrm, tag_o;
  logic [63:0] mem_data;
  logic [79:0] psh_data, dv_a, dv_b, dv_q;
  logic [2:0]  top_o;
  logic        dv_req_valid, dv_req_ready, dv_rsp_valid, dv_rsp_ready, dv_round_up, dv_suppress;

  fdv_seq uut (.*);

  int total = 0, bad = 0;
  int acc_lat = 0, rsp_lat = 0;
  logic sup_next = 1'b0;

  logic [159:0] q_req[$];
  string        q_req_r[$];
  logic [12:0]  q_st[$];
  string        q_st_r[$];

  logic [79:0] mdl [8];
  logic [2:0]  mtop;
  logic [7:0]  mtag;

  logic        req_fire_q = 1'b0, rsp_fire_q = 1'b0;
  logic [79:0] cap_a = '0, cap_b = '0;

  function automatic logic [79:0] q_of(input logic [79:0] a, input logic [79:0] b);
    return a ^ {b[39:0], b[79:40]};
  endfunction
  function automatic logic rnd_of(input logic [79:0] a, input logic [79:0] b);
    return a[3] ^ b[5];
  endfunction

  task automatic chk(input string r, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    req_fire_q <= dv_req_valid && dv_req_ready;
    rsp_fire_q <= dv_rsp_valid && dv_rsp_ready;
    if (dv_req_valid && dv_req_ready) begin
      cap_a <= dv_a;
      cap_b <= dv_b;
    end
  end

  // divider stub
  initial begin
    int ph, cnt;
    ph = 0; cnt = 0;
    dv_req_ready = 0; dv_rsp_valid = 0; dv_q = '0; dv_round_up = 0; dv_suppress = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ph = 0; cnt = 0; dv_req_ready = 0; dv_rsp_valid = 0;
      end else if (ph == 0) begin
        if (req_fire_q) begin dv_req_ready = 0; cnt = 0; ph = 1; end
        else if (dv_req_valid && !dv_req_ready) begin
          if (cnt >= acc_lat) dv_req_ready = 1; else cnt++;
        end
      end else if (ph == 1) begin
        if (cnt >= rsp_lat) begin
          dv_rsp_valid = 1; dv_q = q_of(cap_a, cap_b);
          dv_round_up = rnd_of(cap_a, cap_b); dv_suppress = sup_next; ph = 2;
        end else cnt++;
      end else if (rsp_fire_q) begin
        dv_rsp_valid = 0; cnt = 0; ph = 0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (req_fire_q) begin
        if (q_req.size() == 0) chk("R9 unexpected request", {cap_a, cap_b}, '0);
        else chk(q_req_r.pop_front(), {cap_a, cap_b}, q_req.pop_front());
      end
      if (done) begin
        if (q_st.size() == 0) chk("R11 unexpected done", 160'(1), '0);
        else chk(q_st_r.pop_front(), 160'({stk_fault, c1, top_o, tag_o}), 160'(q_st.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    report();
  end

  task automatic do_push(input logic [79:0] d);
    @(negedge clk);
    psh_valid = 1; psh_data = d;
    @(negedge clk);
    psh_valid = 0;
    mtop = mtop - 3'd1; mdl[mtop] = d; mtag[mtop] = 1'b1;
    chk("R11 push top/tag", 160'({top_o, tag_o}), 160'({mtop, mtag}));
  endtask

  task automatic run_ins(input logic [7:0] opc, input logic [7:0] modrm, input logic [63:0] mem,
                         input logic [79:0] mem_ext, input string r);
    logic ok, is_mem, rev, pop, under, c;
    logic [2:0] pa, pi, dst;
    logic [79:0] a, b, q;
    ok = 0; is_mem = 0; rev = 0; pop = 0;
    if (modrm[7:6] == 2'b11) begin
      if (opc == 8'hD8 && modrm[5:3] == 3'd6) ok = 1;
      else if (opc == 8'hDC && modrm[5:3] == 3'd7) begin ok = 1; rev = 1; end
      else if (opc == 8'hDE && modrm[5:3] == 3'd7) begin ok = 1; rev = 1; pop = 1; end
    end else if (modrm[5:3] == 3'd6 &&
                 (opc == 8'hD8 || opc == 8'hDC || opc == 8'hDA || opc == 8'hDE)) begin
      ok = 1; is_mem = 1;
    end
    pa = mtop; pi = mtop + modrm[2:0];
    under = !mtag[pa] || (!is_mem && !mtag[pi]);
    if (ok) begin
      if (under) begin
        q_st.push_back({1'b1, 1'b0, mtop, mtag}); q_st_r.push_back({r, " fault status"});
      end else begin
        a = rev ? mdl[pi] : mdl[pa];
        b = is_mem ? mem_ext : (rev ? mdl[pa] : mdl[pi]);
        q_req.push_back({a, b}); q_req_r.push_back({r, " operands"});
        q = q_of(a, b);
        c = !sup_next && rnd_of(a, b);
        if (!sup_next) begin
          dst = rev ? pi : pa;
          mdl[dst] = q; mtag[dst] = 1'b1;
          if (pop) begin mtag[mtop] = 1'b0; mtop = mtop + 3'd1; end
        end
        q_st.push_back({1'b0, c, mtop, mtag}); q_st_r.push_back({r, " status"});
      end
    end
    @(negedge clk);
    ins_valid = 1; ins_opc = opc; ins_modrm = modrm; mem_data = mem;
    @(negedge clk);
    ins_valid = 0;
    if (!ok) begin
      for (int k = 0; k < 3; k++) begin
        chk({r, " ignored idle"}, 160'({busy, done, dv_req_valid}), '0);
        @(negedge clk);
      end
      chk({r, " ignored state"}, 160'({top_o, tag_o}), 160'({mtop, mtag}));
    end else begin
      if (!under) chk("R9 busy after accept", 160'(busy), 160'(1));
      while (!done) @(negedge clk);
    end
  endtask

  initial begin
    rst = 1; ins_valid = 0; psh_valid = 0; ins_opc = 0; ins_modrm = 0; mem_data = 0; psh_data = 0;
    mtop = 0; mtag = 0;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset state", 160'({top_o, tag_o, busy, done, stk_fault, c1, dv_req_valid}), '0);

    run_ins(8'hD8, 8'hF1, 64'h0, '0, "R8 empty reg form");
    run_ins(8'hD8, 8'h30, 64'h3F800000, 80'h3FFF_8000000000000000, "R8 empty mem form");

    for (int k = 0; k < 5; k++)
      do_push({16'(16'h3FF0 + k), 48'hA5A5_0F0F_3C3C, 16'(k * 7 + 1)});

    run_ins(8'hD8, 8'hF1, 64'h0, '0, "R2 st0/st1");
    acc_lat = 2; rsp_lat = 3;
    run_ins(8'hDC, 8'hFA, 64'h0, '0, "R3 st2/st0");
    acc_lat = 0; rsp_lat = 0;
    run_ins(8'hD8, 8'hF0, 64'h0, '0, "R2 st0/st0");
    run_ins(8'hD8, 8'hF2, 64'h0, '0, "R3 writeback readback");

    run_ins(8'hD8, 8'h30, 64'hFFFF_FFFF_3F80_0000, 80'h3FFF_8000000000000000, "R5 R7 f32 one");
    acc_lat = 1; rsp_lat = 4;
    run_ins(8'hD8, 8'h35, 64'h0000_0000_C020_0000, 80'hC000_A000000000000000, "R7 f32 neg");
    acc_lat = 0; rsp_lat = 0;
    run_ins(8'hD8, 8'h30, 64'h1, 80'h3F6A_8000000000000000, "R7 f32 denormal");
    run_ins(8'hD8, 8'h30, 64'h7FC0_0000, 80'h7FFF_C000000000000000, "R7 f32 nan");
    run_ins(8'hDC, 8'h70, 64'h4008_0000_0000_0000, 80'h4000_C000000000000000, "R5 R7 f64 three");
    run_ins(8'hDC, 8'hB0, 64'hFFF0_0000_0000_0000, 80'hFFFF_8000000000000000, "R7 f64 neg inf");
    run_ins(8'hDC, 8'h30, 64'h8000_0000_0000_0000, 80'h8000_0000000000000000, "R7 f64 neg zero");
    run_ins(8'hDA, 8'h30, 64'h1234_5678_FFFF_FFFB, 80'hC001_A000000000000000, "R5 R6 i32 minus five");
    run_ins(8'hDA, 8'h30, 64'h1, 80'h3FFF_8000000000000000, "R6 i32 one");
    run_ins(8'hDE, 8'h30, 64'hDEAD_BEEF_1234_8000, 80'hC00E_8000000000000000, "R5 R6 i16 min");
    run_ins(8'hDE, 8'h30, 64'hDEAD_BEEF_1234_0000, '0, "R6 i16 zero");

    run_ins(8'hD8, 8'hF6, 64'h0, '0, "R8 st6 empty");
    run_ins(8'hDC, 8'hFD, 64'h0, '0, "R8 st5 empty");

    sup_next = 1;
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R10 suppressed pop");
    sup_next = 0;

    rsp_lat = 2;
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R4 pop one");
    run_ins(8'hDE, 8'hFA, 64'h0, '0, "R4 pop st2");
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R4 pop two");
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R4 pop three");
    rsp_lat = 0;
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R8 pop with st1 empty");
    run_ins(8'hDE, 8'hF8, 64'h0, '0, "R4 self pop wraps top");
    run_ins(8'hD8, 8'h30, 64'h3F800000, 80'h3FFF_8000000000000000, "R8 empty after wrap");

    run_ins(8'hD9, 8'hF0, 64'h0, '0, "R11 other opcode");
    run_ins(8'hD8, 8'hC1, 64'h0, '0, "R11 reg field not divide");
    run_ins(8'hD8, 8'h28, 64'h0, '0, "R11 mem reg field five");
    run_ins(8'hDA, 8'hF1, 64'h0, '0, "R11 DA register form");

    @(negedge clk);
    ins_valid = 1; ins_opc = 8'hD9; ins_modrm = 8'hF0; psh_valid = 1; psh_data = 80'h1;
    @(negedge clk);
    ins_valid = 0; psh_valid = 0;
    chk("R11 push ignored with instruction", 160'({top_o, tag_o}), 160'({mtop, mtag}));

    do_push(80'h4001_8000000000000000);
    do_push(80'h3FFE_C000000000000000);
    run_ins(8'hDE, 8'hF9, 64'h0, '0, "R4 pop after refill");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", 160'(q_req.size() + q_st.size()), '0);
    report();
  end
endmodule